// File: doc/BRIEF.md
# Read-After-Write Interlock with Switchable Bypass

This block sits beside the decode stage of a five-stage in-order pipeline and decides, each cycle, whether the instruction in decode may leave. It keeps one small countdown per architectural register. There are two separate banks: 32 integer registers and 16 floating-point registers. Each countdown records how many cycles remain until the newest pending producer of that register reaches writeback. A flag beside it marks whether that producer is a load. From these countdowns it raises a stall request and gives one bypass-source select for each source operand.

A single runtime enable chooses between two modes. In the first, results are bypassed from the end-of-execute register or from the memory-stage output register. In the second, every consumer waits until the producer writes back. Execute latency is given per instruction as 1 to 20 cycles. Loads always spend one cycle in execute, and their data is usable only after the memory stage. Branches read their operand in decode and resolve there. The instruction that follows a taken branch is turned into a bubble one cycle later.

Instruction kinds on `dec_kind_i`: 0 = register-writing operation, 1 = load, 2 = store, 3 = branch taken, 4 = branch not taken. Bypass select encoding: 00 = register file, 01 = end-of-execute register, 10 = memory-stage output register.

Top module: `raw_interlock`

## Requirements
- R1: After reset, or after a reset that arrives while producers are pending, no register is pending: `stall_o`=0, `squash_o`=0 and both selects are 00 for any decode instruction.
- R2: A kind-0 producer of latency L leaves decode in cycle c. With bypass enabled, a non-branch consumer of its register stalls in cycles c+1 to c+L-1. It gets select 01 in cycle c+L, select 10 in c+L+1 and select 00 afterwards. Each source is judged on its own, and both selects are 00 whenever `stall_o`=1.
- R3: A load (kind 1) ignores `dec_lat_i` and executes in one cycle. With bypass enabled, a non-branch consumer directly behind it stalls exactly one cycle and then gets select 10.
- R4: With bypass disabled, a consumer stalls until the producer's writeback cycle c+L+2 and may leave in that cycle, and both selects stay 00. The enable is evaluated anew every cycle.
- R5: Branches (kinds 3 and 4) need their operand in decode. With bypass enabled, a kind-0 producer lets the branch leave at c+L+1 with select 01. A load producer lets it leave at c+3 with select 00.
- R6: Stores (kind 2) and branches record no destination, so a later reader of their destination field never stalls on them.
- R7: `*_fp_i`=1 selects the floating-point bank, indexed by the low 4 bits. An integer and a floating-point register with the same number never interact.
- R8: A new producer stalls while an older pending write to the same register would reach writeback in the same cycle or later than the new one (issue cycle + L + 2).
- R9: When two pending producers target one register, the consumer's stall and select follow the younger one.
- R10: In the cycle after a kind-3 branch leaves decode, `squash_o`=1. The instruction then in decode becomes a bubble: no stall, selects 00, and no destination recorded. A kind-4 branch squashes nothing.
- R11: A source with its use flag at 0, or a decode slot with `dec_valid_i`=0, causes no stall and gets select 00. A branch that is stalled squashes nothing.
- R12: A latency of 0 acts as 1, and any latency above 20 acts as 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en_i | input | 1 | 1 = bypassing enabled, 0 = wait for writeback |
| dec_valid_i | input | 1 | Decode slot holds an instruction |
| dec_kind_i | input | 3 | Instruction kind (0 operation, 1 load, 2 store, 3 taken branch, 4 untaken branch) |
| dec_lat_i | input | 5 | Execute latency in cycles |
| dec_dst_i | input | 5 | Destination register number |
| dec_dst_fp_i | input | 1 | Destination is floating-point |
| dec_src1_i | input | 5 | First source register number |
| dec_src1_fp_i | input | 1 | First source is floating-point |
| dec_src1_use_i | input | 1 | First source is read |
| dec_src2_i | input | 5 | Second source register number |
| dec_src2_fp_i | input | 1 | Second source is floating-point |
| dec_src2_use_i | input | 1 | Second source is read |
| stall_o | output | 1 | Hold the decode instruction this cycle |
| squash_o | output | 1 | The decode instruction is cancelled |
| fwd1_sel_o | output | 2 | Bypass source for the first operand |
| fwd2_sel_o | output | 2 | Bypass source for the second operand |

## Verification
Some properties are checked on every cycle. A squash follows a taken branch that leaves decode, and nothing else causes one. A squashed slot neither stalls nor selects a bypass. Selects are 00 while stalled or with bypass disabled. The 11 select code never appears, and a branch never takes the memory-stage select. The exact stall counts for each latency cannot be stated locally, so the bench scenarios show them. The same holds for the load and branch timing, the youngest-producer choice, the write-after-write hold, the separate banks and the latency clamp, which all depend on history across many cycles.

// File: rtl/raw_pkg.sv
package raw_pkg;
    parameter int NUM_INT = 32;
    parameter int NUM_FP  = 16;
    parameter int MAX_LAT = 20;

    localparam int IDX_W   = $clog2(NUM_INT);
    localparam int FPIDX_W = $clog2(NUM_FP);
    localparam int LAT_W   = $clog2(MAX_LAT + 1);
    localparam int CNT_W   = $clog2(MAX_LAT + 3);

    typedef enum logic [2:0] {
        K_OP         = 3'd0,
        K_LOAD       = 3'd1,
        K_STORE      = 3'd2,
        K_BR_TAKEN   = 3'd3,
        K_BR_UNTAKEN = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        SRC_RF     = 2'd0,
        SRC_EXEND  = 2'd1,
        SRC_MEMOUT = 2'd2
    } fwd_e;

    // rem = cycles until the pending producer's writeback cycle; 0 = idle
    typedef struct packed {
        logic             is_load;
        logic [CNT_W-1:0] rem;
    } slot_t;
endpackage

// File: rtl/raw_bank.sv
module raw_bank
    import raw_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int AW = $clog2(NREGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [AW-1:0]       wr_idx_i,
    input  logic                wr_load_i,
    input  logic [CNT_W-1:0]    wr_rem_i,
    output slot_t [NREGS-1:0]   slots_o
);
    for (genvar g = 0; g < NREGS; g++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en_i && wr_idx_i == AW'(g)) begin
                // youngest producer overwrites the older record
                slot_d.is_load = wr_load_i;
                slot_d.rem     = wr_rem_i;
            end else if (slot_q.rem != '0) begin
                slot_d.rem = slot_q.rem - CNT_W'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign slots_o[g] = slot_q;
    end
endmodule

// File: rtl/raw_src_check.sv
module raw_src_check
    import raw_pkg::*;
(
    input  logic  use_i,
    input  logic  is_branch_i,
    input  logic  fwd_en_i,
    input  slot_t slot_i,
    output logic  haz_o,
    output fwd_e  sel_o
);
    logic [CNT_W-1:0] thr;

    always_comb begin
        // largest remaining count at which the operand can still be met
        if (!fwd_en_i)        thr = CNT_W'(0);
        else if (is_branch_i) thr = slot_i.is_load ? CNT_W'(0) : CNT_W'(1);
        else                  thr = slot_i.is_load ? CNT_W'(1) : CNT_W'(2);

        haz_o = use_i && (slot_i.rem > thr);

        sel_o = SRC_RF;
        if (use_i && !haz_o && fwd_en_i) begin
            if (is_branch_i) begin
                if (slot_i.rem == CNT_W'(1)) sel_o = SRC_EXEND;
            end else if (slot_i.rem == CNT_W'(2)) begin
                sel_o = SRC_EXEND;
            end else if (slot_i.rem == CNT_W'(1)) begin
                sel_o = SRC_MEMOUT;
            end
        end
    end
endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
    import raw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_en_i,
    input  logic             dec_valid_i,
    input  logic [2:0]       dec_kind_i,
    input  logic [LAT_W-1:0] dec_lat_i,
    input  logic [IDX_W-1:0] dec_dst_i,
    input  logic             dec_dst_fp_i,
    input  logic [IDX_W-1:0] dec_src1_i,
    input  logic             dec_src1_fp_i,
    input  logic             dec_src1_use_i,
    input  logic [IDX_W-1:0] dec_src2_i,
    input  logic             dec_src2_fp_i,
    input  logic             dec_src2_use_i,
    output logic             stall_o,
    output logic             squash_o,
    output logic [1:0]       fwd1_sel_o,
    output logic [1:0]       fwd2_sel_o
);
    typedef struct packed {
        logic squash;
    } state_t;

    state_t st_d, st_q;

    slot_t [NUM_INT-1:0] int_slots;
    slot_t [NUM_FP-1:0]  fp_slots;

    kind_e            kind;
    logic             live, is_br, writes, issue;
    logic [CNT_W-1:0] lat_eff;
    slot_t            s1_slot, s2_slot, d_slot;
    logic             haz1, haz2, waw;
    fwd_e             sel1, sel2;

    assign kind   = kind_e'(dec_kind_i);
    assign live   = dec_valid_i && !st_q.squash;
    assign is_br  = (kind == K_BR_TAKEN) || (kind == K_BR_UNTAKEN);
    assign writes = (kind == K_OP) || (kind == K_LOAD);

    // R12: latency clamped into 1..MAX_LAT; R3: load always one cycle
    always_comb begin
        if (kind == K_LOAD)
            lat_eff = CNT_W'(1);
        else if (dec_lat_i == '0)
            lat_eff = CNT_W'(1);
        else if (dec_lat_i > LAT_W'(MAX_LAT))
            lat_eff = CNT_W'(MAX_LAT);
        else
            lat_eff = CNT_W'(dec_lat_i);
    end

    // R7: separate banks
    assign s1_slot = dec_src1_fp_i ? fp_slots[dec_src1_i[FPIDX_W-1:0]] : int_slots[dec_src1_i];
    assign s2_slot = dec_src2_fp_i ? fp_slots[dec_src2_i[FPIDX_W-1:0]] : int_slots[dec_src2_i];
    assign d_slot  = dec_dst_fp_i  ? fp_slots[dec_dst_i[FPIDX_W-1:0]]  : int_slots[dec_dst_i];

    raw_src_check u_chk1 (
        .use_i      (live && dec_src1_use_i),
        .is_branch_i(is_br),
        .fwd_en_i   (fwd_en_i),
        .slot_i     (s1_slot),
        .haz_o      (haz1),
        .sel_o      (sel1)
    );

    raw_src_check u_chk2 (
        .use_i      (live && dec_src2_use_i),
        .is_branch_i(is_br),
        .fwd_en_i   (fwd_en_i),
        .slot_i     (s2_slot),
        .haz_o      (haz2),
        .sel_o      (sel2)
    );

    // R8: older write must land strictly before this one
    assign waw     = live && writes && (d_slot.rem >= lat_eff + CNT_W'(2));
    assign stall_o = haz1 || haz2 || waw;
    assign issue   = live && !stall_o;

    raw_bank #(.NREGS(NUM_INT)) u_int_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (issue && writes && !dec_dst_fp_i),
        .wr_idx_i (dec_dst_i),
        .wr_load_i(kind == K_LOAD),
        .wr_rem_i (lat_eff + CNT_W'(1)),
        .slots_o  (int_slots)
    );

    raw_bank #(.NREGS(NUM_FP)) u_fp_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (issue && writes && dec_dst_fp_i),
        .wr_idx_i (dec_dst_i[FPIDX_W-1:0]),
        .wr_load_i(kind == K_LOAD),
        .wr_rem_i (lat_eff + CNT_W'(1)),
        .slots_o  (fp_slots)
    );

    // R10: cancel the slot behind a taken branch that left decode
    always_comb begin
        st_d        = st_q;
        st_d.squash = issue && (kind == K_BR_TAKEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign squash_o   = st_q.squash;
    assign fwd1_sel_o = stall_o ? 2'(SRC_RF) : 2'(sel1);
    assign fwd2_sel_o = stall_o ? 2'(SRC_RF) : 2'(sel2);
endmodule

// File: rtl/raw_interlock_chk.sv
module raw_interlock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fwd_en_i,
    input logic       dec_valid_i,
    input logic [2:0] dec_kind_i,
    input logic       dec_src1_use_i,
    input logic       dec_src2_use_i,
    input logic       stall_o,
    input logic       squash_o,
    input logic [1:0] fwd1_sel_o,
    input logic [1:0] fwd2_sel_o
);
    logic taken_leaves;
    assign taken_leaves = dec_valid_i && dec_kind_i == 3'd3 && !stall_o && !squash_o;

    assert_squash_follows_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        taken_leaves |=> squash_o);

    assert_squash_only_after_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> $past(taken_leaves));

    assert_squash_is_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> (!stall_o && fwd1_sel_o == 2'd0 && fwd2_sel_o == 2'd0));

    assert_stall_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> dec_valid_i);

    assert_unused_src_rf_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_src1_use_i |-> fwd1_sel_o == 2'd0) and (!dec_src2_use_i |-> fwd2_sel_o == 2'd0));

    assert_nofwd_regfile_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en_i |-> (fwd1_sel_o == 2'd0 && fwd2_sel_o == 2'd0));

    assert_stall_no_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (fwd1_sel_o == 2'd0 && fwd2_sel_o == 2'd0));

    assert_sel_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd1_sel_o != 2'd3 && fwd2_sel_o != 2'd3);

    assert_branch_no_memout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_kind_i == 3'd3 || dec_kind_i == 3'd4) |-> fwd1_sel_o != 2'd2);
endmodule

bind raw_interlock raw_interlock_chk u_raw_interlock_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fwd_en_i      (fwd_en_i),
    .dec_valid_i   (dec_valid_i),
    .dec_kind_i    (dec_kind_i),
    .dec_src1_use_i(dec_src1_use_i),
    .dec_src2_use_i(dec_src2_use_i),
    .stall_o       (stall_o),
    .squash_o      (squash_o),
    .fwd1_sel_o    (fwd1_sel_o),
    .fwd2_sel_o    (fwd2_sel_o)
);

// File: tb/raw_interlock_bench.sv
module raw_interlock_bench;
    localparam int CLK_NS = 20;
    localparam int NROWS  = 48;

    typedef struct packed {
        logic       v;
        logic [2:0] k;
        logic [4:0] lat;
        logic [4:0] d;
        logic       dfp;
        logic [4:0] a;
        logic       afp;
        logic       au;
        logic [4:0] b;
        logic       bfp;
        logic       bu;
        logic       fe;
        logic       xst;
        logic       xsq;
        logic [1:0] x1;
        logic [1:0] x2;
        logic [3:0] req;
    } vec_t;

    function automatic vec_t mk(int v, int k, int lat, int d, int dfp, int a, int afp, int au,
                                int b, int bfp, int bu, int fe, int st, int sq, int x1, int x2,
                                int req);
        vec_t t;
        t.v = 1'(v);   t.k = 3'(k);     t.lat = 5'(lat); t.d = 5'(d);  t.dfp = 1'(dfp);
        t.a = 5'(a);   t.afp = 1'(afp); t.au = 1'(au);   t.b = 5'(b);  t.bfp = 1'(bfp);
        t.bu = 1'(bu); t.fe = 1'(fe);   t.xst = 1'(st);  t.xsq = 1'(sq);
        t.x1 = 2'(x1); t.x2 = 2'(x2);   t.req = 4'(req);
        return t;
    endfunction

    // one row per clock: v k lat d dfp a afp au b bfp bu fe | stall squash sel1 sel2 | req
    localparam vec_t TBL [NROWS] = '{
        mk(1,0,1, 5,0,  1,0,1,  2,0,1, 1, 0,0,0,0,  2),  // R2 producer r5
        mk(1,0,1, 6,0,  5,0,1,  5,0,1, 1, 0,0,1,1,  2),  // R2 right behind: 01
        mk(1,0,1, 7,0,  5,0,1,  6,0,1, 1, 0,0,2,1,  2),  // R2 one later: 10
        mk(1,0,1, 8,0,  5,0,1,  6,0,1, 1, 0,0,0,2,  2),  // R2 written back: 00
        mk(1,0,3, 9,0,  7,0,0,  8,0,0, 1, 0,0,0,0, 11),  // R11 unused sources
        mk(1,0,1,10,0,  9,0,1,  0,0,0, 1, 1,0,0,0,  2),  // R2 latency 3 stall
        mk(1,0,1,10,0,  9,0,1,  0,0,0, 1, 1,0,0,0,  2),
        mk(1,0,1,10,0,  9,0,1,  0,0,0, 1, 0,0,1,0,  2),  // R2 leaves at c+L
        mk(1,1,7,11,0, 10,0,1,  0,0,0, 1, 0,0,1,0,  3),  // R3 load, latency ignored
        mk(1,0,1,12,0, 11,0,1,  0,0,0, 1, 1,0,0,0,  3),  // R3 one stall
        mk(1,0,1,12,0, 11,0,1,  0,0,0, 1, 0,0,2,0,  3),  // R3 then 10
        mk(1,0,1,13,0, 12,0,1,  0,0,0, 0, 1,0,0,0,  4),  // R4 no bypass
        mk(1,0,1,13,0, 12,0,1,  0,0,0, 0, 1,0,0,0,  4),
        mk(1,0,1,13,0, 12,0,1,  0,0,0, 0, 0,0,0,0,  4),  // R4 writeback cycle
        mk(1,0,1,14,0,  0,0,0, 13,0,1, 0, 1,0,0,0,  4),
        mk(1,0,1,14,0,  0,0,0, 13,0,1, 1, 0,0,0,2,  4),  // R4 enable toggled
        mk(1,3,1, 0,0, 14,0,1,  0,0,0, 1, 1,0,0,0,  5),  // R5 taken branch waits
        mk(1,3,1, 0,0, 14,0,1,  0,0,0, 1, 0,0,1,0,  5),  // R5 leaves with 01
        mk(1,0,20,15,0,14,0,1,  0,0,0, 1, 0,1,0,0, 10),  // R10 squashed slot
        mk(1,0,1,16,0, 15,0,1,  0,0,0, 1, 0,0,0,0, 10),  // R10 no dst recorded
        mk(1,4,1, 0,0, 16,0,1,  0,0,0, 1, 1,0,0,0,  5),  // R5 untaken branch waits
        mk(1,4,1, 0,0, 16,0,1,  0,0,0, 1, 0,0,1,0,  5),
        mk(1,0,1,17,0, 16,0,1,  0,0,0, 1, 0,0,0,0, 10),  // R10 untaken: no squash
        mk(1,1,1,18,0,  1,0,1,  0,0,0, 1, 0,0,0,0,  3),  // load r18
        mk(1,3,1, 0,0, 18,0,1,  0,0,0, 1, 1,0,0,0,  5),  // R5 branch on load
        mk(1,3,1, 0,0, 18,0,1,  0,0,0, 1, 1,0,0,0, 11),  // R11 stalled branch
        mk(1,3,1, 0,0, 18,0,1,  0,0,0, 1, 0,0,0,0,  5),  // R5 leaves at c+3, 00
        mk(1,0,1, 2,0,  1,0,1,  0,0,0, 1, 0,1,0,0, 10),  // R10 squash
        mk(1,2,1,19,0,  3,0,1,  4,0,1, 1, 0,0,0,0,  6),  // R6 store
        mk(1,0,1,21,0, 19,0,1,  0,0,0, 1, 0,0,0,0,  6),  // R6 no hazard on r19
        mk(1,4,1,20,0,  2,0,1,  0,0,0, 1, 0,0,0,0,  6),  // R6 branch, r2 clean
        mk(1,0,4, 3,1, 20,0,1,  0,0,0, 1, 0,0,0,0,  6),  // fp f3 producer, L=4
        mk(1,0,1,22,0,  3,0,1,  0,0,0, 1, 0,0,0,0,  7),  // R7 int r3 independent
        mk(1,0,1,24,0,  3,1,1,  0,0,0, 1, 1,0,0,0,  7),  // R7 fp f3 pending
        mk(1,0,1,24,0,  3,1,1,  0,0,0, 1, 1,0,0,0,  7),
        mk(1,0,1,24,0,  3,1,1,  0,0,0, 1, 0,0,1,0,  7),
        mk(1,0,4,23,0,  0,0,0,  0,0,0, 1, 0,0,0,0,  8),  // R8 slow producer
        mk(1,0,1,23,0,  0,0,0,  0,0,0, 1, 1,0,0,0,  8),  // R8 fast would overtake
        mk(1,0,1,23,0,  0,0,0,  0,0,0, 1, 1,0,0,0,  8),
        mk(1,0,1,23,0,  0,0,0,  0,0,0, 1, 1,0,0,0,  8),  // R8 equal cycle still stalls
        mk(1,0,1,23,0,  0,0,0,  0,0,0, 1, 0,0,0,0,  8),
        mk(1,0,1,24,0, 23,0,1,  0,0,0, 1, 0,0,1,0,  9),  // R9 younger r23
        mk(1,0,1,25,0,  0,0,0,  0,0,0, 1, 0,0,0,0,  9),
        mk(1,0,1,25,0,  0,0,0,  0,0,0, 1, 0,0,0,0,  8),  // R8 later WB: no stall
        mk(1,0,1,27,0, 25,0,1,  0,0,0, 1, 0,0,1,0,  9),  // R9 younger gives 01
        mk(1,0,0,26,0,  0,0,0,  0,0,0, 1, 0,0,0,0, 12),  // R12 latency 0
        mk(1,0,1,28,0, 26,0,1,  0,0,0, 1, 0,0,1,0, 12),  // R12 acts as 1
        mk(0,0,0, 0,0,  0,0,0,  0,0,0, 1, 0,0,0,0, 11)   // R11 empty slot
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fwd_en_i = 1'b1;
    logic       dec_valid_i = 1'b0;
    logic [2:0] dec_kind_i = '0;
    logic [4:0] dec_lat_i = '0;
    logic [4:0] dec_dst_i = '0;
    logic       dec_dst_fp_i = 1'b0;
    logic [4:0] dec_src1_i = '0;
    logic       dec_src1_fp_i = 1'b0;
    logic       dec_src1_use_i = 1'b0;
    logic [4:0] dec_src2_i = '0;
    logic       dec_src2_fp_i = 1'b0;
    logic       dec_src2_use_i = 1'b0;
    logic       stall_o, squash_o;
    logic [1:0] fwd1_sel_o, fwd2_sel_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    raw_interlock u_raw_interlock (
        .clk(clk), .rst_n(rst_n), .fwd_en_i(fwd_en_i), .dec_valid_i(dec_valid_i),
        .dec_kind_i(dec_kind_i), .dec_lat_i(dec_lat_i), .dec_dst_i(dec_dst_i),
        .dec_dst_fp_i(dec_dst_fp_i), .dec_src1_i(dec_src1_i), .dec_src1_fp_i(dec_src1_fp_i),
        .dec_src1_use_i(dec_src1_use_i), .dec_src2_i(dec_src2_i),
        .dec_src2_fp_i(dec_src2_fp_i), .dec_src2_use_i(dec_src2_use_i),
        .stall_o(stall_o), .squash_o(squash_o), .fwd1_sel_o(fwd1_sel_o), .fwd2_sel_o(fwd2_sel_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t t);
        dec_valid_i = t.v;   dec_kind_i = t.k;     dec_lat_i = t.lat;
        dec_dst_i = t.d;     dec_dst_fp_i = t.dfp;
        dec_src1_i = t.a;    dec_src1_fp_i = t.afp; dec_src1_use_i = t.au;
        dec_src2_i = t.b;    dec_src2_fp_i = t.bfp; dec_src2_use_i = t.bu;
        fwd_en_i = t.fe;
    endtask

    // all outputs packed as {stall, squash, sel1, sel2}
    function automatic int outs();
        return int'({stall_o, squash_o, fwd1_sel_o, fwd2_sel_o});
    endfunction

    initial begin
        #(CLK_NS * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        drive(mk(0,0,0,0,0,0,0,0,0,0,0,1,0,0,0,0,1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing pending after reset
        @(negedge clk);
        drive(mk(1,0,1,0,0,5,0,1,9,1,1,1,0,0,0,0,1));
        #2 chk("R1 reset state", outs(), 0);

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            #2;
            n_chk++;
            if ({stall_o, squash_o, fwd1_sel_o, fwd2_sel_o} != {TBL[i].xst, TBL[i].xsq, TBL[i].x1, TBL[i].x2}) begin
                n_bad++;
                $display("FAIL R%0d row %0d: got st=%b sq=%b s1=%0d s2=%0d expected st=%b sq=%b s1=%0d s2=%0d",
                         TBL[i].req, i, stall_o, squash_o, fwd1_sel_o, fwd2_sel_o,
                         TBL[i].xst, TBL[i].xsq, TBL[i].x1, TBL[i].x2);
            end
        end

        // R12: latency 31 acts as 20, so 19 stall cycles behind it
        @(negedge clk);
        drive(mk(1,0,31,29,0,0,0,0,0,0,0,1,0,0,0,0,12));
        begin
            int stalls = 0;
            for (int j = 0; j < 40; j++) begin
                @(negedge clk);
                drive(mk(1,0,1,31,0,29,0,1,0,0,0,1,0,0,0,0,12));
                #2;
                if (!stall_o) break;
                stalls++;
            end
            chk("R12 clamp stall count", stalls, 19);
            chk("R12 select on release", int'(fwd1_sel_o), 1);
        end

        // R1: reset while a long producer is pending
        @(negedge clk);
        drive(mk(1,0,20,30,0,0,0,0,0,0,0,1,0,0,0,0,1));
        @(negedge clk);
        drive(mk(0,0,0,0,0,0,0,0,0,0,0,1,0,0,0,0,1));
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        drive(mk(1,0,1,4,0,30,0,1,30,0,1,1,0,0,0,0,1));
        #2 chk("R1 reset clears pending", outs(), 0);

        @(negedge clk);
        drive(mk(0,0,0,0,0,0,0,0,0,0,0,1,0,0,0,0,1));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule